// File: doc/BRIEF.md
# Event-Gated Microsecond Interval Timer

This block measures the time between two hardware events in whole microseconds. A free prescaler divides the system clock down to a one-microsecond tick, and a saturating counter adds one for each tick taken between a start event and a stop event. Typical use: software arms the timer, the first breakpoint match starts it, and the second breakpoint match freezes the result for readout.

The counter covers a 16-second span (16,000,000 µs in a 24-bit register by default). A run that lasts longer saturates at that limit and raises a sticky overflow flag. The result and the flags hold after the stop event until the next arm command.

Top module: `us_interval_timer`

## Requirements
- R1: After reset, count_o is 0, running_o, done_o and ovf_o are low, and the timer is idle: start_i and stop_i have no effect until arm_i has been seen.
- R2: An arm_i pulse in any state clears count_o, done_o and ovf_o and leaves the timer armed and not running. arm_i wins over start_i or stop_i in the same cycle.
- R3: start_i while armed sets running_o and restarts the prescaler, so the first increment comes exactly TICK_DIV cycles after the start edge, whatever the prescaler held before.
- R4: While running, count_o rises by exactly one every TICK_DIV clock cycles and never by more than one per cycle.
- R5: stop_i while running clears running_o and sets done_o. A tick in the stop cycle is not counted, so with the stop sampled G cycles after the start, count_o = floor((G-1)/TICK_DIV).
- R6: stop_i while idle or armed, including in the same cycle as an accepted start, is ignored.
- R7: start_i while running or done is ignored: the count is not restarted and done_o stays set.
- R8: After a stop, count_o holds its value until the next arm.
- R9: count_o never exceeds LIMIT (default 16,000,000). A tick that would take it past LIMIT leaves it at LIMIT and sets ovf_o, which stays set until the next arm. ovf_o is only set while count_o equals LIMIT.
- R10: running_o and done_o are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Clear the result and wait for a start event |
| start_i | input | 1 | Start event (first breakpoint match) |
| stop_i | input | 1 | Stop event (second breakpoint match) |
| count_o | output | CNT_W | Elapsed microseconds |
| running_o | output | 1 | Counting is in progress |
| done_o | output | 1 | A stop event ended the measurement |
| ovf_o | output | 1 | Sticky: the interval exceeded LIMIT |

## Verification
On every cycle the assertions check the bound on the count, the one-step increment while running, the frozen count when not running, the clearing effect of arm, the stickiness of overflow and its link to a saturated count, and that running and done exclude each other. Only the bench's scenarios can show the exact count for a given start-to-stop distance, including the dropped tick in the stop cycle and the prescaler realignment after an aborted run. The same holds for the events ignored before arming, before starting and after stopping. Random gaps with a reduced tick divider and limit cover both ordinary and overflowing runs.

// File: rtl/it_pkg.sv
package it_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } it_state_e;
endpackage

// File: rtl/it_prescaler.sv
module it_prescaler #(
  parameter int TICK_DIV = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

  logic [PW-1:0] div_q;
  logic          wrap;

  assign wrap   = (div_q == LAST);
  assign tick_o = en_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (en_i)   div_q <= wrap ? '0 : div_q + 1'b1;
  end
endmodule

// File: rtl/it_ctrl.sv
module it_ctrl
  import it_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic start_i,
  input  logic stop_i,
  output logic run_o,
  output logic done_o,
  output logic start_go_o,
  output logic stop_go_o
);
  it_state_e state_q, state_d;

  assign start_go_o = (state_q == ST_ARMED) && start_i && !arm_i;
  assign stop_go_o  = (state_q == ST_RUN) && stop_i && !arm_i;

  always_comb begin
    state_d = state_q;
    if (arm_i)           state_d = ST_ARMED;
    else if (start_go_o) state_d = ST_RUN;
    else if (stop_go_o)  state_d = ST_DONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign run_o  = (state_q == ST_RUN);
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/it_counter.sv
module it_counter #(
  parameter int CNT_W = 24,
  parameter int LIMIT = 16_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  logic at_limit;
  assign at_limit = (count_o == LIMIT_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else if (clr_i) begin
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else if (inc_i) begin
      if (at_limit) ovf_o   <= 1'b1;
      else          count_o <= count_o + 1'b1;
    end
  end
endmodule

// File: rtl/us_interval_timer.sv
module us_interval_timer #(
  parameter int TICK_DIV = 10,
  parameter int CNT_W    = 24,
  parameter int LIMIT    = 16_000_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             done_o,
  output logic             ovf_o
);
  logic run, start_go, stop_go, tick;

  it_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_i      (arm_i),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .run_o      (run),
    .done_o     (done_o),
    .start_go_o (start_go),
    .stop_go_o  (stop_go)
  );

  // realign the microsecond phase on every accepted start
  it_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_go),
    .en_i   (run),
    .tick_o (tick)
  );

  // tick coinciding with the stop edge is dropped
  it_counter #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (arm_i),
    .inc_i   (tick && !stop_go),
    .count_o (count_o),
    .ovf_o   (ovf_o)
  );

  assign running_o = run;
endmodule

// File: rtl/us_interval_timer_chk.sv
module us_interval_timer_chk #(
  parameter int CNT_W = 24,
  parameter int LIMIT = 16_000_000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             arm_i,
  input logic [CNT_W-1:0] count_o,
  input logic             running_o,
  input logic             done_o,
  input logic             ovf_o
);
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(LIMIT);

  // R9
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= LIMIT_C);

  // R9
  ovf_at_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> count_o == LIMIT_C);

  // R9
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !arm_i |=> ovf_o);

  // R10
  run_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(running_o && done_o));

  // R2
  arm_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> count_o == '0 && !done_o && !ovf_o && !running_o);

  // R4
  step_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && !arm_i |=> count_o == $past(count_o) || count_o == $past(count_o) + 1'b1);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o && !arm_i |=> $stable(count_o) && !$rose(ovf_o));
endmodule

bind us_interval_timer us_interval_timer_chk #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .arm_i     (arm_i),
  .count_o   (count_o),
  .running_o (running_o),
  .done_o    (done_o),
  .ovf_o     (ovf_o)
);

// File: tb/us_interval_timer_tb_top.sv
`timescale 1ns/1ps
module us_interval_timer_tb_top;
  localparam int DIV = 4;
  localparam int LIM = 50;
  localparam int CW  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm = 1'b0, start = 1'b0, stop = 1'b0;
  logic [CW-1:0] count;
  logic running, done, ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  us_interval_timer #(.TICK_DIV(DIV), .CNT_W(CW), .LIMIT(LIM)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .start_i(start), .stop_i(stop),
    .count_o(count), .running_o(running), .done_o(done), .ovf_o(ovf)
  );

  function automatic int raw_ticks(int gap);
    return (gap - 1) / DIV;
  endfunction
  function automatic int exp_count(int gap);
    return (raw_ticks(gap) > LIM) ? LIM : raw_ticks(gap);
  endfunction
  function automatic int exp_ovf(int gap);
    return (raw_ticks(gap) > LIM) ? 1 : 0;
  endfunction

  task automatic check(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // start at one edge, stop sampled gap edges later; optional extra start at step mid
  task automatic measure(int gap, int mid, string req);
    @(negedge clk); start = 1'b1;
    for (int i = 1; i <= gap; i++) begin
      @(negedge clk);
      if (i == 1) check(int'(running), 1, "R3 running after start");
      start = (mid != 0 && i == mid);
      stop  = (i == gap);
    end
    @(negedge clk); start = 1'b0; stop = 1'b0;
    check(int'(count), exp_count(gap), req);
    check(int'(ovf), exp_ovf(gap), "R9 overflow flag");
    check(int'(done), 1, "R5 done after stop");
    check(int'(running), 0, "R5 running cleared");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int gap;
    int held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(int'(count), 0, "R1 count");
    check(int'(running | done | ovf), 0, "R1 flags");
    // R1 start/stop before arm ignored
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (DIV * 3) @(negedge clk);
    check(int'(running), 0, "R1 start ignored when idle");
    check(int'(count), 0, "R1 count idle");

    // R6 stop while armed ignored
    pulse_arm();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
    check(int'(done), 0, "R6 stop ignored when armed");
    check(int'(running), 0, "R6 not running");

    // R6 start and stop in same cycle: start taken, stop ignored
    start = 1'b1; stop = 1'b1; @(negedge clk); start = 1'b0; stop = 1'b0;
    check(int'(running), 1, "R6 same-cycle stop ignored");
    check(int'(done), 0, "R6 not done");
    pulse_arm();

    // directed boundaries (R4, R5)
    measure(1, 0, "R5 gap 1"); pulse_arm();
    measure(DIV, 0, "R5 tick in stop cycle dropped"); pulse_arm();
    measure(DIV + 1, 0, "R4 first tick"); pulse_arm();
    measure(10 * DIV + 3, 0, "R4 steady count"); pulse_arm();
    measure(LIM * DIV + 1, 0, "R9 reach limit no overflow"); pulse_arm();
    measure(LIM * DIV + DIV + 1, 0, "R9 saturate"); 

    // R8 hold after stop; R7 start ignored when done
    held = int'(count);
    repeat (DIV * 5) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (DIV * 2) @(negedge clk);
    check(int'(count), held, "R8 count held");
    check(int'(done), 1, "R7 start ignored when done");
    check(int'(running), 0, "R7 not restarted");

    // R2 arm clears overflowed result
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    check(int'(count), 0, "R2 count cleared");
    check(int'(ovf | done | running), 0, "R2 flags cleared");

    // R7 start while running ignored
    measure(9 * DIV + 2, 2 * DIV + 1, "R7 restart ignored"); pulse_arm();

    // R2 arm during run, then R3 prescaler realigned
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (DIV * 3 + 1) @(negedge clk);
    arm = 1'b1; start = 1'b1; @(negedge clk); arm = 1'b0; start = 1'b0;
    check(int'(running), 0, "R2 arm aborts run, wins over start");
    check(int'(count), 0, "R2 count cleared mid-run");
    measure(3 * DIV + 1, 0, "R3 prescaler realigned"); pulse_arm();

    // random gaps
    for (int n = 0; n < 30; n++) begin
      gap = 1 + int'($urandom % (LIM * DIV + 3 * DIV));
      measure(gap, 0, "R5 random gap");
      pulse_arm();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule